// File: doc/BRIEF.md
# Charge-Sampling Voltage Sensor Sequencer

This block is the digital controller for a supply-voltage sensor built around a small sampling capacitor and a self-timed counter. It runs sensing rounds. In each round the capacitor is first filled from the supply. The capacitor is then connected to the counter, whose activity it powers, for a fixed window. After the window, the counter is stopped by closing a bypass path and its value is captured. Last, the capacitor is emptied. The captured count is a digital measure of the supply voltage at the moment of sampling, and no stable reference is needed.

The charge, conversion and discharge times are given as cycle counts. They are sampled when a round begins. A single pulse on the start input runs one round. With the continuous input held high, a new round follows each discharge with no gap. The analog switches, the capacitor and the counter are outside the block. The counter's value arrives on `count_i`, and the block can saturate it to a narrower result width.

Top module: `vsense_seq`

## Requirements
- R1: A synchronous reset puts the block in idle. In idle, every switch, discharge and counter control output is low, `result_o` is zero and `valid_o` is low.
- R2: A round opens with a charge phase of max(chg_cyc_i,1) cycles. During this phase `chg_sw_o` is high and `conn_sw_o` is low.
- R3: `chg_sw_o` and `conn_sw_o` are never high in the same cycle. Exactly one cycle with every output low separates the charge phase from the conversion phase.
- R4: The conversion phase lasts max(conv_cyc_i,1) cycles. `conn_sw_o` and `cnt_en_o` are high together in this phase and in no other.
- R5: `byp_sw_o` is high for exactly one cycle, straight after conversion. `count_i` is captured in that cycle. In the following cycle `result_o` shows the capture and `valid_o` is high for one cycle.
- R6: When RES_W is below CNT_W, a count above 2^RES_W-1 is captured as all ones. Otherwise the count is captured unchanged.
- R7: A discharge phase of max(dis_cyc_i,1) cycles follows the bypass cycle. `dis_en_o` and `cnt_clr_o` are both high for its whole length.
- R8: `valid_o` is low except in the cycle after a bypass cycle. `result_o` keeps its value between captures.
- R9: A start pulse in idle runs exactly one round, and the block then returns to idle. A start pulse during a round has no effect.
- R10: When `cont_i` is high at the end of discharge, the next cycle is the first charge cycle of a new round.
- R11: The three durations are sampled when a round begins. Changing them during the round does not change that round's phase lengths.
- R12: Durations are DUR_W-bit counts (16 by default). At a 200 MHz clock this covers rounds of 100, 400 and 1000 cycles for charge plus conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts one round when idle |
| cont_i | input | 1 | Back-to-back rounds while high |
| chg_cyc_i | input | DUR_W | Charge phase length in cycles |
| conv_cyc_i | input | DUR_W | Conversion phase length in cycles |
| dis_cyc_i | input | DUR_W | Discharge phase length in cycles |
| count_i | input | CNT_W | Value of the external counter |
| chg_sw_o | output | 1 | Supply-to-capacitor switch enable |
| conn_sw_o | output | 1 | Capacitor-to-counter switch enable |
| byp_sw_o | output | 1 | Bypass switch enable (stops the counter) |
| dis_en_o | output | 1 | Capacitor discharge enable |
| cnt_en_o | output | 1 | Counter run enable |
| cnt_clr_o | output | 1 | Counter clear |
| result_o | output | RES_W | Captured measurement |
| valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
The bench builds the block with DUR_W=16, CNT_W=8 and RES_W=4. The narrow result width brings the saturating capture variant within reach using conversion windows of only 16 to 20 cycles. The narrow counter makes the long 5 µs round wrap the count. The bench sweeps every combination of charge lengths {0,1,2,5}, conversion lengths {0,1,3,15,16,20} and discharge lengths {0,1,4}, so the zero-means-one rule and the saturation boundary are both covered. The 16-bit duration width is kept so that rounds of 100, 400 and 1000 cycles can be run in full.

// File: rtl/vsense_pkg.sv
package vsense_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_CHARGE = 3'd1,
      PH_DEAD   = 3'd2,
      PH_CONV   = 3'd3,
      PH_LATCH  = 3'd4,
      PH_DISCH  = 3'd5
   } phase_t;

endpackage

// File: rtl/vsense_timer.sv
module vsense_timer #(
   parameter int DUR_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [DUR_W-1:0] val_i,
   output logic             done_o
);

   logic [DUR_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)              cnt_q <= '0;
      else if (load_i)        cnt_q <= val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   // the interval counter steps down by one per cycle until reloaded
   p_step_down_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/vsense_ctrl.sv
module vsense_ctrl
   import vsense_pkg::*;
#(
   parameter int DUR_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             start_i,
   input  logic             cont_i,
   input  logic [DUR_W-1:0] chg_cyc_i,
   input  logic [DUR_W-1:0] conv_cyc_i,
   input  logic [DUR_W-1:0] dis_cyc_i,
   input  logic             tmr_done_i,
   output logic             tmr_load_o,
   output logic [DUR_W-1:0] tmr_val_o,
   output phase_t           phase_o
);

   phase_t           phase_q, phase_d;
   logic [DUR_W-1:0] conv_q, dis_q;
   logic             round_go;

   // a zero length behaves as one cycle; the timer wants length minus one
   function automatic logic [DUR_W-1:0] len_m1(input logic [DUR_W-1:0] n);
      return (n == '0) ? '0 : n - 1'b1;
   endfunction

   always_comb begin
      phase_d    = phase_q;
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      unique case (phase_q)
         PH_IDLE: if (start_i) begin
            phase_d    = PH_CHARGE;
            tmr_load_o = 1'b1;
            tmr_val_o  = len_m1(chg_cyc_i);
         end
         PH_CHARGE: if (tmr_done_i) phase_d = PH_DEAD;
         PH_DEAD: begin
            phase_d    = PH_CONV;
            tmr_load_o = 1'b1;
            tmr_val_o  = len_m1(conv_q);
         end
         PH_CONV: if (tmr_done_i) phase_d = PH_LATCH;
         PH_LATCH: begin
            phase_d    = PH_DISCH;
            tmr_load_o = 1'b1;
            tmr_val_o  = len_m1(dis_q);
         end
         PH_DISCH: if (tmr_done_i) begin
            if (cont_i) begin
               phase_d    = PH_CHARGE;
               tmr_load_o = 1'b1;
               tmr_val_o  = len_m1(chg_cyc_i);
            end else begin
               phase_d = PH_IDLE;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   assign round_go = tmr_load_o && (phase_d == PH_CHARGE);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= PH_IDLE;
         conv_q  <= '0;
         dis_q   <= '0;
      end else begin
         phase_q <= phase_d;
         if (round_go) begin
            conv_q <= conv_cyc_i;
            dis_q  <= dis_cyc_i;
         end
      end
   end

   assign phase_o = phase_q;

   // a busy round ignores start: only idle or a finished discharge can begin one
   p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_q == PH_CONV) |=> (phase_q == PH_CONV || phase_q == PH_LATCH));

   // dead cycle always precedes conversion
   p_dead_before_conv_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_q == PH_CONV && $past(phase_q) != PH_CONV) |-> ($past(phase_q) == PH_DEAD));

endmodule

// File: rtl/vsense_capture.sv
module vsense_capture #(
   parameter int CNT_W = 12,
   parameter int RES_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             latch_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [RES_W-1:0] result_o,
   output logic             valid_o
);

   logic [RES_W-1:0] cap;

   generate
      if (RES_W >= CNT_W) begin : g_widen
         assign cap = RES_W'(count_i);
      end else begin : g_clip
         assign cap = (|count_i[CNT_W-1:RES_W]) ? {RES_W{1'b1}} : count_i[RES_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         result_o <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= latch_i;
         if (latch_i) result_o <= cap;
      end
   end

   p_valid_after_latch_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> $past(latch_i));

   p_result_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(latch_i) |-> $stable(result_o));

endmodule

// File: rtl/vsense_seq.sv
module vsense_seq
   import vsense_pkg::*;
#(
   parameter int DUR_W = 16,
   parameter int CNT_W = 12,
   parameter int RES_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             start_i,
   input  logic             cont_i,
   input  logic [DUR_W-1:0] chg_cyc_i,
   input  logic [DUR_W-1:0] conv_cyc_i,
   input  logic [DUR_W-1:0] dis_cyc_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             chg_sw_o,
   output logic             conn_sw_o,
   output logic             byp_sw_o,
   output logic             dis_en_o,
   output logic             cnt_en_o,
   output logic             cnt_clr_o,
   output logic [RES_W-1:0] result_o,
   output logic             valid_o
);

   generate
      if (DUR_W < 2 || DUR_W > 32) begin : g_bad_dur
         $error("vsense_seq: DUR_W must lie in 2..32");
      end
      if (CNT_W < 1 || RES_W < 1) begin : g_bad_cnt
         $error("vsense_seq: CNT_W and RES_W must be positive");
      end
   endgenerate

   phase_t           phase;
   logic             tmr_load, tmr_done;
   logic [DUR_W-1:0] tmr_val;

   vsense_ctrl #(.DUR_W(DUR_W)) ctrl_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .start_i    (start_i),
      .cont_i     (cont_i),
      .chg_cyc_i  (chg_cyc_i),
      .conv_cyc_i (conv_cyc_i),
      .dis_cyc_i  (dis_cyc_i),
      .tmr_done_i (tmr_done),
      .tmr_load_o (tmr_load),
      .tmr_val_o  (tmr_val),
      .phase_o    (phase)
   );

   vsense_timer #(.DUR_W(DUR_W)) timer_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .done_o (tmr_done)
   );

   vsense_capture #(.CNT_W(CNT_W), .RES_W(RES_W)) cap_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .latch_i  (byp_sw_o),
      .count_i  (count_i),
      .result_o (result_o),
      .valid_o  (valid_o)
   );

   assign chg_sw_o  = (phase == PH_CHARGE);
   assign conn_sw_o = (phase == PH_CONV);
   assign cnt_en_o  = (phase == PH_CONV);
   assign byp_sw_o  = (phase == PH_LATCH);
   assign dis_en_o  = (phase == PH_DISCH);
   assign cnt_clr_o = (phase == PH_DISCH);

   p_switch_excl_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !(chg_sw_o && conn_sw_o));

   p_gap_after_charge_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(chg_sw_o) |-> (!conn_sw_o && !byp_sw_o && !dis_en_o));

   p_count_only_connected_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_en_o |-> (conn_sw_o && !dis_en_o && !byp_sw_o));

   p_bypass_one_cycle_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      byp_sw_o |=> (!byp_sw_o && dis_en_o));

   p_discharge_isolated_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      dis_en_o |-> (cnt_clr_o && !chg_sw_o && !conn_sw_o));

endmodule

// File: tb/vsense_seq_tb_top.sv
`timescale 1ns/1ps
module vsense_seq_tb_top;

   localparam int DUR_W = 16;
   localparam int CNT_W = 8;
   localparam int RES_W = 4;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             start = 1'b0;
   logic             cont = 1'b0;
   logic [DUR_W-1:0] chg_cyc = '0, conv_cyc = '0, dis_cyc = '0;
   logic [CNT_W-1:0] cnt_q = '0;
   logic             chg_sw, conn_sw, byp_sw, dis_en, cnt_en, cnt_clr, valid;
   logic [RES_W-1:0] result;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   vsense_seq #(.DUR_W(DUR_W), .CNT_W(CNT_W), .RES_W(RES_W)) dut_i (
      .clk_i(clk), .rst_i(rst), .start_i(start), .cont_i(cont),
      .chg_cyc_i(chg_cyc), .conv_cyc_i(conv_cyc), .dis_cyc_i(dis_cyc),
      .count_i(cnt_q),
      .chg_sw_o(chg_sw), .conn_sw_o(conn_sw), .byp_sw_o(byp_sw),
      .dis_en_o(dis_en), .cnt_en_o(cnt_en), .cnt_clr_o(cnt_clr),
      .result_o(result), .valid_o(valid)
   );

   // model of the self-timed counter
   always_ff @(posedge clk) begin
      if (rst || cnt_clr) cnt_q <= '0;
      else if (cnt_en)    cnt_q <= cnt_q + 1'b1;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int nz(input int n);
      return (n == 0) ? 1 : n;
   endfunction

   function automatic int expect_res(input int v);
      int m = nz(v) % (1 << CNT_W);
      return (m > (1 << RES_W) - 1) ? (1 << RES_W) - 1 : m;
   endfunction

   // R3: switches exclusive on every sampled cycle
   always @(negedge clk) if (!rst) chk(!(chg_sw && conn_sw), "R3 exclusive", {chg_sw, conn_sw}, 0);

   task automatic idle_check(input string req);
      chk({chg_sw, conn_sw, byp_sw, dis_en, cnt_en, cnt_clr} == 6'b0, req,
          {chg_sw, conn_sw, byp_sw, dis_en, cnt_en, cnt_clr}, 0);
   endtask

   // entered at the negedge of the first charge cycle; leaves at the negedge after discharge
   task automatic measure(input int c, input int v, input int d, input bit mut, input bit poke);
      int n;
      n = 0;
      while (chg_sw && n < 70000) begin
         if (mut && n == 0) begin
            chg_cyc  = DUR_W'(c + 3);
            conv_cyc = DUR_W'(v + 5);
            dis_cyc  = DUR_W'(d + 2);
         end
         n++; @(negedge clk);
      end
      chk(n == nz(c), mut ? "R11 charge" : "R2 charge length", n, nz(c));
      n = 0;
      while (!conn_sw && n < 10) begin
         idle_check("R3 dead cycle");
         n++; @(negedge clk);
      end
      chk(n == 1, "R3 dead length", n, 1);
      n = 0;
      while (conn_sw && n < 70000) begin
         if (poke) start = (n == 0);
         chk(cnt_en == 1'b1, "R4 counter enable", cnt_en, 1);
         n++; @(negedge clk);
      end
      start = 1'b0;
      chk(n == nz(v), mut ? "R11 conversion" : "R4 conversion length", n, nz(v));
      chk(cnt_en == 1'b0, "R4 enable off", cnt_en, 0);
      n = 0;
      while (byp_sw && n < 10) begin
         chk(valid == 1'b0, "R8 no early valid", valid, 0);
         n++; @(negedge clk);
      end
      chk(n == 1, "R5 bypass length", n, 1);
      chk(valid == 1'b1, "R5 valid strobe", valid, 1);
      chk(int'(result) == expect_res(v), "R6 captured result", result, expect_res(v));
      n = 0;
      while (dis_en && n < 70000) begin
         if (n > 0) chk(valid == 1'b0, "R8 single valid", valid, 0);
         chk(cnt_clr == 1'b1, "R7 counter clear", cnt_clr, 1);
         n++; @(negedge clk);
      end
      chk(n == nz(d), mut ? "R11 discharge" : "R7 discharge length", n, nz(d));
   endtask

   task automatic single_round(input int c, input int v, input int d, input bit mut, input bit poke);
      chg_cyc  = DUR_W'(c);
      conv_cyc = DUR_W'(v);
      dis_cyc  = DUR_W'(d);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      measure(c, v, d, mut, poke);
      idle_check("R9 back to idle");
      repeat (2) @(negedge clk);
      chk(int'(result) == expect_res(v) && !valid, "R8 result held", result, expect_res(v));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int cl[4] = '{0, 1, 2, 5};
      int vl[6] = '{0, 1, 3, 15, 16, 20};
      int dl[3] = '{0, 1, 4};
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      idle_check("R1 reset outputs");
      chk(result == '0 && !valid, "R1 reset result", result, 0);

      foreach (cl[i]) foreach (vl[j]) foreach (dl[k])
         single_round(cl[i], vl[j], dl[k], 1'b0, 1'b0);

      single_round(2, 5, 2, 1'b1, 1'b0);   // R11 mid-round change
      single_round(3, 4, 2, 1'b0, 1'b1);   // R9 start during conversion

      // R10 continuous rounds
      cont = 1'b1;
      chg_cyc = 16'd3; conv_cyc = 16'd4; dis_cyc = 16'd2;
      start = 1'b1; @(negedge clk); start = 1'b0;
      measure(3, 4, 2, 1'b0, 1'b0);
      chk(chg_sw == 1'b1, "R10 immediate restart", chg_sw, 1);
      cont = 1'b0;
      measure(3, 4, 2, 1'b0, 1'b0);
      idle_check("R10 stop when cleared");

      // R12 round periods of 500 ns, 2 us and 5 us at 200 MHz
      single_round(40, 60, 3, 1'b0, 1'b0);
      single_round(100, 300, 3, 1'b0, 1'b0);
      single_round(400, 600, 10, 1'b0, 1'b0);
      chk(int'(result) == 15, "R12 long round result", result, 15);

      // R1 reset in the middle of a round
      chg_cyc = 16'd8; conv_cyc = 16'd8; dis_cyc = 16'd2;
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      idle_check("R1 reset mid-round");
      chk(result == '0 && !valid, "R1 result cleared", result, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule